// File: doc/BRIEF.md
# Two-Subphase Bus Address Parity Unit

This block sits on a shared, multi-agent front-side bus whose address phase takes two consecutive bus cycles on the same wires. In the first subphase the wires carry a 37-bit physical address, made of address lines 39 down to 3. In the second subphase the same wires carry transaction-type information. A 5-bit request field is sent in both subphases. Every bus wire is active-low. The block keeps logical values inside and inverts them at its pins. Parity is always computed on the electrical levels.

The block has two independent halves. The requester half launches a transaction when `tx_go_i` is taken. It then drives the two parity wires one bus cycle after each subphase's data, and it can force address line 20 to its non-asserted level. The monitor half watches the bus. When it sees the address strobe low it recaptures both subphases, recomputes parity, and gives a one-cycle mismatch pulse for each parity wire and each subphase.

Two wire groups are used. The high group is address vector bits 36:21, which are address lines 39:24. The low group is address vector bits 20:0 (lines 23:3) together with all 5 request bits. A correct parity wire is electrically high when an even number of the wires it covers are electrically low. The two parity wires swap which group they cover between the two subphases.

Top module: `addr_parity_unit`

## Requirements
- R1: While reset is high, and on the first cycle after it, the strobe, address, request and parity outputs are all electrically high, and both mismatch outputs are zero.
- R2: When `tx_go_i` is taken at a clock edge, the next cycle drives the strobe low, the address pins with the inverted address and the request pins with the inverted first request field. The cycle after that drives the strobe high, the address pins with the inverted type word and the request pins with the inverted second request field. With no transaction active, the strobe, address and request pins are electrically high.
- R3: In the cycle after the strobe-low cycle, parity bit 0 covers the high group and parity bit 1 covers the low group, both taken from the first subphase's electrical levels. A parity wire is high when its count of low covered wires is even.
- R4: In the second cycle after the strobe-low cycle, the coverage swaps and is taken from the second subphase's levels. Parity bit 1 covers the high group and parity bit 0 covers the low group.
- R5: Outside the two cycles named in R3 and R4, both parity outputs are electrically high.
- R6: When `mask_bit_i` is high as a transaction is taken, address vector bit 17 (line 20) is driven electrically high in the first subphase. The other bits are unchanged, and the second subphase is unaffected.
- R7: A `tx_go_i` that arrives in a cycle whose bus cycle is a first subphase is ignored. A `tx_go_i` during a second subphase is taken, so transactions can start every second cycle and the strobe is never low in two consecutive cycles.
- R8: After the monitor samples the strobe low to open a transaction at cycle c, `perr_sp1_o[b]` is high for one cycle, in cycle c+2, if the parity wire b received in cycle c+1 differs from the R3 parity recomputed from the address and request values of cycle c.
- R9: `perr_sp2_o[b]` is high for one cycle, in cycle c+3, if the parity wire b received in cycle c+2 differs from the R4 parity recomputed from the values of cycle c+1.
- R10: A strobe sampled low in the cycle right after an opening strobe belongs to the second subphase and does not open a new transaction.
- R11: Both mismatch outputs are zero in every cycle that R8 and R9 do not name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_go_i | input | 1 | Start a transaction |
| tx_addr_i | input | 37 | Logical physical address, lines 39:3 |
| tx_kind_i | input | 37 | Logical second-subphase type word |
| tx_cmd1_i | input | 5 | Logical request field, first subphase |
| tx_cmd2_i | input | 5 | Logical request field, second subphase |
| mask_bit_i | input | 1 | Force address line 20 non-asserted |
| bus_strobe_n_o | output | 1 | Driven address strobe, active-low |
| bus_addr_n_o | output | 37 | Driven address wires, active-low |
| bus_req_n_o | output | 5 | Driven request wires, active-low |
| bus_par_n_o | output | 2 | Driven parity wires, electrical |
| mon_strobe_n_i | input | 1 | Observed address strobe |
| mon_addr_n_i | input | 37 | Observed address wires |
| mon_req_n_i | input | 5 | Observed request wires |
| mon_par_n_i | input | 2 | Observed parity wires |
| perr_sp1_o | output | 2 | Mismatch pulse per parity wire, subphase 1 |
| perr_sp2_o | output | 2 | Mismatch pulse per parity wire, subphase 2 |

## Verification
If the requester's phase state goes wrong, the strobe or the address pins show it within one cycle. A wrong coverage mapping or polarity shows on the parity pins in the very next cycle. If the monitor's capture state goes wrong, its errors appear two or three cycles after a strobe. They show up as missing or spurious mismatch pulses, or as a pulse on the wrong bit. They are most visible when strobes come in consecutive cycles or when only one parity wire is corrupted.

// File: rtl/apu_pkg.sv
`timescale 1ns/1ps
package apu_pkg;
  typedef enum logic {
    SUBPH_ONE = 1'b0,
    SUBPH_TWO = 1'b1
  } subph_e;
endpackage

// File: rtl/apu_par_calc.sv
`timescale 1ns/1ps
// Electrical-level parity for one subphase; coverage swaps with subphase.
module apu_par_calc
  import apu_pkg::*;
#(
  parameter int ADDR_W = 37,
  parameter int REQ_W  = 5,
  parameter int HI_W   = 16
) (
  input  logic [ADDR_W-1:0] addr_e_i,
  input  logic [REQ_W-1:0]  req_e_i,
  input  subph_e            sp_i,
  output logic [1:0]        par_e_o
);
  localparam int LO_W = ADDR_W - HI_W;

  logic hi_low_odd;
  logic lo_low_odd;
  logic hi_wire;
  logic lo_wire;

  // odd count of electrically low wires -> parity wire low
  always_comb begin
    hi_low_odd = ^(~addr_e_i[ADDR_W-1:LO_W]);
    lo_low_odd = (^(~addr_e_i[LO_W-1:0])) ^ (^(~req_e_i));
    hi_wire    = ~hi_low_odd;
    lo_wire    = ~lo_low_odd;
    if (sp_i == SUBPH_ONE) par_e_o = {lo_wire, hi_wire};
    else                   par_e_o = {hi_wire, lo_wire};
  end
endmodule

// File: rtl/apu_requester.sv
`timescale 1ns/1ps
module apu_requester
  import apu_pkg::*;
#(
  parameter int ADDR_W   = 37,
  parameter int REQ_W    = 5,
  parameter int HI_W     = 16,
  parameter int MASK_BIT = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] kind_i,
  input  logic [REQ_W-1:0]  cmd1_i,
  input  logic [REQ_W-1:0]  cmd2_i,
  input  logic              mask_i,
  output logic              strobe_n_o,
  output logic [ADDR_W-1:0] addr_n_o,
  output logic [REQ_W-1:0]  req_n_o,
  output logic [1:0]        par_n_o
);
  logic              in_sp1;
  logic              in_sp2;
  logic              take;
  logic [ADDR_W-1:0] addr_masked;
  logic [ADDR_W-1:0] kind_q;
  logic [REQ_W-1:0]  cmd2_q;
  logic [1:0]        par_next;
  subph_e            cur_sp;

  assign take   = go_i && !in_sp1;
  assign cur_sp = in_sp1 ? SUBPH_ONE : SUBPH_TWO;

  always_comb begin
    addr_masked = addr_i;
    if (mask_i) addr_masked[MASK_BIT] = 1'b0;
  end

  // parity computed on the levels currently on the pins
  apu_par_calc #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_calc (
    .addr_e_i (addr_n_o),
    .req_e_i  (req_n_o),
    .sp_i     (cur_sp),
    .par_e_o  (par_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sp1     <= 1'b0;
      in_sp2     <= 1'b0;
      strobe_n_o <= 1'b1;
      addr_n_o   <= '1;
      req_n_o    <= '1;
      par_n_o    <= '1;
      kind_q     <= '0;
      cmd2_q     <= '0;
    end else begin
      in_sp1 <= take;
      in_sp2 <= in_sp1;
      if (in_sp1 || in_sp2) par_n_o <= par_next;
      else                  par_n_o <= '1;
      if (take) begin
        strobe_n_o <= 1'b0;
        addr_n_o   <= ~addr_masked;
        req_n_o    <= ~cmd1_i;
        kind_q     <= kind_i;
        cmd2_q     <= cmd2_i;
      end else if (in_sp1) begin
        strobe_n_o <= 1'b1;
        addr_n_o   <= ~kind_q;
        req_n_o    <= ~cmd2_q;
      end else begin
        strobe_n_o <= 1'b1;
        addr_n_o   <= '1;
        req_n_o    <= '1;
      end
    end
  end

  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe_n_o |=> strobe_n_o);

  assert_mask_high_R6: assert property (@(posedge clk) disable iff (rst)
    (take && mask_i) |=> addr_n_o[MASK_BIT]);

  assert_par_released_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_sp1 && !in_sp2) |=> (&par_n_o));

  assert_pins_released_R2: assert property (@(posedge clk) disable iff (rst)
    (!take && !in_sp1) |=> (strobe_n_o && (&addr_n_o) && (&req_n_o)));
endmodule

// File: rtl/apu_checker.sv
`timescale 1ns/1ps
module apu_checker
  import apu_pkg::*;
#(
  parameter int ADDR_W = 37,
  parameter int REQ_W  = 5,
  parameter int HI_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n_i,
  input  logic [ADDR_W-1:0] addr_n_i,
  input  logic [REQ_W-1:0]  req_n_i,
  input  logic [1:0]        par_n_i,
  output logic [1:0]        err_sp1_o,
  output logic [1:0]        err_sp2_o
);
  localparam int NSP = 2;

  logic              v1;
  logic              v2;
  logic              start;
  logic [ADDR_W-1:0] a_q   [NSP];
  logic [REQ_W-1:0]  r_q   [NSP];
  logic [1:0]        exp_p [NSP];

  // a strobe during the second subphase does not open a transaction
  assign start = !strobe_n_i && !v1;

  for (genvar g = 0; g < NSP; g++) begin : g_sp
    apu_par_calc #(.ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)) u_calc (
      .addr_e_i (a_q[g]),
      .req_e_i  (r_q[g]),
      .sp_i     ((g == 0) ? SUBPH_ONE : SUBPH_TWO),
      .par_e_o  (exp_p[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      err_sp1_o <= '0;
      err_sp2_o <= '0;
      for (int i = 0; i < NSP; i++) begin
        a_q[i] <= '1;
        r_q[i] <= '1;
      end
    end else begin
      v1 <= start;
      v2 <= v1;
      if (start) begin
        a_q[0] <= addr_n_i;
        r_q[0] <= req_n_i;
      end
      if (v1) begin
        a_q[1] <= addr_n_i;
        r_q[1] <= req_n_i;
      end
      err_sp1_o <= v1 ? (exp_p[0] ^ par_n_i) : 2'b00;
      err_sp2_o <= v2 ? (exp_p[1] ^ par_n_i) : 2'b00;
    end
  end

  assert_err1_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    (|err_sp1_o) |=> !(|err_sp1_o));

  assert_err2_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    (|err_sp2_o) |=> !(|err_sp2_o));

  assert_no_double_open_R10: assert property (@(posedge clk) disable iff (rst)
    v1 |-> !v2);

  assert_err_order_R11: assert property (@(posedge clk) disable iff (rst)
    (|err_sp2_o) |-> !(|err_sp1_o));
endmodule

// File: rtl/addr_parity_unit.sv
`timescale 1ns/1ps
module addr_parity_unit #(
  parameter int ADDR_W   = 37,
  parameter int REQ_W    = 5,
  parameter int HI_W     = 16,
  parameter int MASK_BIT = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_go_i,
  input  logic [ADDR_W-1:0] tx_addr_i,
  input  logic [ADDR_W-1:0] tx_kind_i,
  input  logic [REQ_W-1:0]  tx_cmd1_i,
  input  logic [REQ_W-1:0]  tx_cmd2_i,
  input  logic              mask_bit_i,
  output logic              bus_strobe_n_o,
  output logic [ADDR_W-1:0] bus_addr_n_o,
  output logic [REQ_W-1:0]  bus_req_n_o,
  output logic [1:0]        bus_par_n_o,
  input  logic              mon_strobe_n_i,
  input  logic [ADDR_W-1:0] mon_addr_n_i,
  input  logic [REQ_W-1:0]  mon_req_n_i,
  input  logic [1:0]        mon_par_n_i,
  output logic [1:0]        perr_sp1_o,
  output logic [1:0]        perr_sp2_o
);
  apu_requester #(
    .ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W), .MASK_BIT(MASK_BIT)
  ) u_req (
    .clk        (clk),
    .rst        (rst),
    .go_i       (tx_go_i),
    .addr_i     (tx_addr_i),
    .kind_i     (tx_kind_i),
    .cmd1_i     (tx_cmd1_i),
    .cmd2_i     (tx_cmd2_i),
    .mask_i     (mask_bit_i),
    .strobe_n_o (bus_strobe_n_o),
    .addr_n_o   (bus_addr_n_o),
    .req_n_o    (bus_req_n_o),
    .par_n_o    (bus_par_n_o)
  );

  apu_checker #(
    .ADDR_W(ADDR_W), .REQ_W(REQ_W), .HI_W(HI_W)
  ) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_n_i (mon_strobe_n_i),
    .addr_n_i   (mon_addr_n_i),
    .req_n_i    (mon_req_n_i),
    .par_n_i    (mon_par_n_i),
    .err_sp1_o  (perr_sp1_o),
    .err_sp2_o  (perr_sp2_o)
  );
endmodule

// File: tb/sim_addr_parity_unit.sv
`timescale 1ns/1ps
module sim_addr_parity_unit;
  localparam int AW = 37;
  localparam int RW = 5;
  localparam int HW = 16;
  localparam int MB = 17;
  localparam int DEPTH = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          go = 1'b0;
  logic [AW-1:0] t_addr = '0, t_kind = '0;
  logic [RW-1:0] t_c1 = '0, t_c2 = '0;
  logic          t_mask = 1'b0;
  logic          m_s = 1'b1;
  logic [AW-1:0] m_a = '1;
  logic [RW-1:0] m_r = '1;
  logic [1:0]    m_p = 2'b11;
  logic          b_s;
  logic [AW-1:0] b_a;
  logic [RW-1:0] b_r;
  logic [1:0]    b_p, e1, e2;

  addr_parity_unit u0 (
    .clk(clk), .rst(rst), .tx_go_i(go), .tx_addr_i(t_addr), .tx_kind_i(t_kind),
    .tx_cmd1_i(t_c1), .tx_cmd2_i(t_c2), .mask_bit_i(t_mask),
    .bus_strobe_n_o(b_s), .bus_addr_n_o(b_a), .bus_req_n_o(b_r), .bus_par_n_o(b_p),
    .mon_strobe_n_i(m_s), .mon_addr_n_i(m_a), .mon_req_n_i(m_r), .mon_par_n_i(m_p),
    .perr_sp1_o(e1), .perr_sp2_o(e2)
  );

  // next-cycle stimulus
  logic          nx_rst = 1'b1, nx_go = 1'b0, nx_mask = 1'b0;
  logic [AW-1:0] nx_addr = '0, nx_kind = '0;
  logic [RW-1:0] nx_c1 = '0, nx_c2 = '0;
  logic          loop_en = 1'b0;
  logic [AW-1:0] flip_a = '0;
  logic [1:0]    flip_p = '0;
  logic          nx_ms = 1'b1;
  logic [AW-1:0] nx_ma = '1;
  logic [RW-1:0] nx_mr = '1;
  logic [1:0]    nx_mp = 2'b11;

  int checks = 0, failures = 0;
  int n = 8;
  int strobe_seen = 0, err_seen = 0;

  // reference model storage, indexed by edge number
  logic          x_s [DEPTH];
  logic [AW-1:0] x_a [DEPTH];
  logic [RW-1:0] x_r [DEPTH];
  logic [1:0]    x_p [DEPTH];
  logic [1:0]    x_e1 [DEPTH];
  logic [1:0]    x_e2 [DEPTH];
  logic [AW-1:0] o_a [DEPTH];
  logic [RW-1:0] o_r [DEPTH];
  logic [1:0]    o_p [DEPTH];
  logic          o_open [DEPTH];

  function automatic int ix(int k);
    return k % DEPTH;
  endfunction

  // parity from the electrical rule: wire high when the number of low covered wires is even
  function automatic logic [1:0] ref_par(logic [AW-1:0] a, logic [RW-1:0] r, int sp);
    int zh = 0, zl = 0;
    logic hi, lo;
    for (int i = 0; i < AW; i++) begin
      if (a[i] == 1'b0) begin
        if (i >= AW - HW) zh++;
        else zl++;
      end
    end
    for (int i = 0; i < RW; i++) if (r[i] == 1'b0) zl++;
    hi = (zh % 2) == 0;
    lo = (zl % 2) == 0;
    return (sp == 1) ? {lo, hi} : {hi, lo};
  endfunction

  task automatic clear_slot(int k);
    x_s[ix(k)] = 1'b1; x_a[ix(k)] = '1; x_r[ix(k)] = '1; x_p[ix(k)] = 2'b11;
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h (edge %0d)", tag, act, exp, n);
    end
  endtask

  task automatic compare_outputs();
    int k = ix(n);
    chk("R2 R7 strobe", 64'(b_s), 64'(x_s[k]));
    chk("R2 R6 addr", 64'(b_a), 64'(x_a[k]));
    chk("R2 req", 64'(b_r), 64'(x_r[k]));
    chk("R3 R4 R5 parity", 64'(b_p), 64'(x_p[k]));
    chk("R8 R10 R11 perr_sp1", 64'(e1), 64'(x_e1[k]));
    chk("R9 R10 R11 perr_sp2", 64'(e2), 64'(x_e2[k]));
    if (b_s == 1'b0) strobe_seen++;
    if ((e1 | e2) != 2'b00) err_seen++;
  endtask

  task automatic model_step();
    logic [AW-1:0] am;
    n++;
    if (rst) begin
      clear_slot(n); clear_slot(n + 1); clear_slot(n + 2);
      o_open[ix(n)] = 1'b0; x_e1[ix(n)] = 2'b00; x_e2[ix(n)] = 2'b00;
      o_a[ix(n)] = m_a; o_r[ix(n)] = m_r; o_p[ix(n)] = m_p;
    end else begin
      clear_slot(n + 2);
      if (go && x_s[ix(n - 1)] !== 1'b0) begin
        am = t_addr;
        if (t_mask) am[MB] = 1'b0;
        x_s[ix(n)] = 1'b0; x_a[ix(n)] = ~am; x_r[ix(n)] = ~t_c1;
        x_a[ix(n + 1)] = ~t_kind; x_r[ix(n + 1)] = ~t_c2;
        x_p[ix(n + 1)] = ref_par(x_a[ix(n)], x_r[ix(n)], 1);
        x_p[ix(n + 2)] = ref_par(x_a[ix(n + 1)], x_r[ix(n + 1)], 2);
      end
      o_a[ix(n)] = m_a; o_r[ix(n)] = m_r; o_p[ix(n)] = m_p;
      o_open[ix(n)] = !m_s && !o_open[ix(n - 1)];
      x_e1[ix(n)] = o_open[ix(n - 1)] ?
        (ref_par(o_a[ix(n - 1)], o_r[ix(n - 1)], 1) ^ m_p) : 2'b00;
      x_e2[ix(n)] = o_open[ix(n - 2)] ?
        (ref_par(o_a[ix(n - 1)], o_r[ix(n - 1)], 2) ^ m_p) : 2'b00;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_outputs();
    rst = nx_rst; go = nx_go; t_addr = nx_addr; t_kind = nx_kind;
    t_c1 = nx_c1; t_c2 = nx_c2; t_mask = nx_mask;
    if (loop_en) begin
      m_s = b_s; m_a = b_a ^ flip_a; m_r = b_r; m_p = b_p ^ flip_p;
    end else begin
      m_s = nx_ms; m_a = nx_ma; m_r = nx_mr; m_p = nx_mp;
    end
    @(posedge clk);
    model_step();
  endtask

  task automatic idle(int k);
    nx_go = 1'b0;
    for (int i = 0; i < k; i++) tick();
  endtask

  task automatic load_rand(logic m);
    nx_addr = AW'({$urandom(), $urandom()});
    nx_kind = AW'({$urandom(), $urandom()});
    nx_c1 = RW'($urandom()); nx_c2 = RW'($urandom());
    nx_mask = m;
  endtask

  task automatic send(logic m);
    load_rand(m);
    nx_go = 1'b1;
    tick();
    nx_go = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      clear_slot(i);
      x_e1[i] = 2'b00; x_e2[i] = 2'b00; o_open[i] = 1'b0;
      o_a[i] = '1; o_r[i] = '1; o_p[i] = 2'b11;
    end
    // R1: reset
    nx_rst = 1'b1;
    idle(4);
    nx_rst = 1'b0;
    idle(1);
    #1;
    chk("R1 strobe", 64'(b_s), 64'(1'b1));
    chk("R1 addr", 64'(b_a), 64'({AW{1'b1}}));
    chk("R1 parity", 64'(b_p), 64'(2'b11));
    chk("R1 perr", 64'({e1, e2}), 64'(0));

    // R2-R5, R8: loopback with clean bus
    loop_en = 1'b1;
    for (int i = 0; i < 6; i++) begin send(1'b0); idle(4); end

    // R6: mask forces line 20 high in subphase 1 only
    load_rand(1'b1);
    nx_addr[MB] = 1'b1; nx_kind[MB] = 1'b1; nx_go = 1'b1;
    tick(); nx_go = 1'b0;
    #1 chk("R6 masked bit subphase 1", 64'(b_a[MB]), 64'(1'b1));
    tick();
    #1 chk("R6 bit in subphase 2", 64'(b_a[MB]), 64'(1'b0));
    idle(4);
    load_rand(1'b0);
    nx_addr[MB] = 1'b1; nx_go = 1'b1;
    tick(); nx_go = 1'b0;
    #1 chk("R6 unmasked bit", 64'(b_a[MB]), 64'(1'b0));
    idle(4);

    // R7: go on three consecutive cycles -> two strobes
    strobe_seen = 0;
    for (int i = 0; i < 3; i++) begin load_rand(1'b0); nx_go = 1'b1; tick(); end
    idle(5);
    chk("R7 strobes from three gos", 64'(strobe_seen), 64'(2));
    strobe_seen = 0;
    for (int i = 0; i < 8; i++) begin load_rand(i[0]); nx_go = 1'b1; tick(); end
    idle(5);
    chk("R7 continuous go", 64'(strobe_seen), 64'(4));

    // R8/R9: corrupted parity and address in loopback
    err_seen = 0;
    flip_p = 2'b01;
    for (int i = 0; i < 3; i++) begin send(1'b0); idle(4); end
    chk("R8 errors reported on corrupted parity", 64'(err_seen > 0), 64'(1));
    flip_p = 2'b10;
    for (int i = 0; i < 3; i++) begin send(1'b0); idle(3); end
    flip_p = 2'b00; flip_a = '0; flip_a[30] = 1'b1;
    for (int i = 0; i < 3; i++) begin send(1'b1); idle(3); end
    flip_a = '0; flip_a[2] = 1'b1;
    for (int i = 0; i < 4; i++) send(1'b0);
    idle(4);
    flip_a = '0;

    // R10/R11: raw monitor patterns
    loop_en = 1'b0;
    for (int run = 1; run <= 4; run++) begin
      for (int i = 0; i < run; i++) begin
        nx_ms = 1'b0; nx_ma = AW'({$urandom(), $urandom()});
        nx_mr = RW'($urandom()); nx_mp = 2'($urandom());
        tick();
      end
      nx_ms = 1'b1; nx_mp = 2'($urandom());
      idle(4);
    end
    for (int i = 0; i < 200; i++) begin
      nx_ms = ($urandom() % 3) != 0; nx_ma = AW'({$urandom(), $urandom()});
      nx_mr = RW'($urandom()); nx_mp = 2'($urandom());
      tick();
    end
    nx_ms = 1'b1;
    idle(6);
    summary();
  end
endmodule